// File: doc/BRIEF.md
# UART Automatic Bit-Rate Detector

This block finds the bit rate of an asynchronous host before any normal serial traffic takes place. The host repeats a zero byte with eight data bits, one stop bit and no parity. Each such byte puts one low run on the line that lasts nine bit times: the start bit followed by eight zero data bits. A high gap of at least one bit time separates each run from the next. The block passes the receive line through a two-stage synchroniser. It then counts, in system clocks, how long each low run lasts. From the first run of plausible length it derives the divisor for a receiver that samples sixteen times per bit.

After it accepts a measurement, the block stops looking at the line. It transmits one zero byte at the measured rate so that the host knows adjustment is complete. Once that byte's stop bit has gone out, a sticky locked flag rises. The divisor output then holds its value for the rest of the session, and only a reset starts a new detection.

Top module: `autobaud_lock`

## Requirements
- R1: While reset is applied and just after it is released, `tx_o` is 1, `locked_o` is 0 and `divisor_o` is 0.
- R2: A low run is timed as the exact number of clock edges at which `rx_i` was sampled low between a high-to-low and a low-to-high transition. `rx_i` passes through two synchroniser flops before this timing.
- R3: For an accepted run of L clocks, `divisor_o` becomes floor((L + 72) / 144), which is L divided by 9 bits times 16 samples, rounded to nearest.
- R4: A low run shorter than `MIN_LOW` clocks (default 144) is discarded: no frame is sent, `divisor_o` stays 0, and the next falling edge starts a fresh measurement.
- R5: A low run longer than 2^`CNT_W` - 1 clocks is discarded the same way, and measurement restarts on a later falling edge. A run of exactly 2^`CNT_W` - 1 clocks is accepted.
- R6: After a run is accepted, `tx_o` sends one confirmation byte of value zero. It is driven 0 for exactly 144 x D clocks (start bit and eight zero data bits, each 16 x D clocks, with D the new divisor) and then returns to 1 for the stop bit.
- R7: `locked_o` rises exactly 16 x D + 1 clocks after `tx_o` returns to 1 at the start of the stop bit, and stays 1 until reset.
- R8: Low runs that arrive while the confirmation byte is in flight or after lock are ignored: `divisor_o` keeps its value and no further frame appears on `tx_o`.
- R9: `tx_o` is 1 at all times outside the confirmation frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line from the host, asynchronous to `clk_i` |
| tx_o | output | 1 | Serial line to the host, idles high |
| divisor_o | output | DIV_W | Clocks per 16x sample tick; 0 until a run is accepted |
| locked_o | output | 1 | High once the confirmation byte has been fully sent |

## Verification
Random run lengths in the accepted range are compared with a bench model of the rounded divisor and with the exact length of the returned frame. The directed lengths 144, 215 and 216 lie on either side of a rounding step, so they show whether the count is exact to one clock and whether rounding is to nearest rather than truncating. Runs one clock below the minimum and one clock above the counter limit must produce silence, and a following good run must still lock; this separates the discard paths from a stuck measurement. Extra low runs sent while the frame is in flight and after lock show that the first accepted measurement is frozen.

// File: rtl/abd_pkg.sv
package abd_pkg;

    // Top-level sequencing of detection, confirmation and lock
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SEND = 2'd1,
        ST_DONE = 2'd2
    } abd_state_e;

endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/abd_measure.sv
module abd_measure #(
    parameter int CNT_W   = 20,
    parameter int MIN_LOW = 144
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rx_s_i,
    input  logic             en_i,
    output logic             len_vld_o,
    output logic [CNT_W-1:0] len_o
);

    localparam logic [CNT_W-1:0] MAX_CNT = '1;
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LOW);

    typedef struct packed {
        logic             run;
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        logic [CNT_W-1:0] len;
    } meas_t;

    meas_t q, d;

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        d.prev = rx_s_i;
        if (!q.run) begin
            // arm only on a genuine high-to-low transition
            if (en_i && q.prev && !rx_s_i) begin
                d.run = 1'b1;
                d.cnt = CNT_W'(1);
            end
        end else if (!rx_s_i) begin
            if (q.cnt == MAX_CNT) begin
                d.run = 1'b0;          // too long: drop, wait for next fall
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.run = 1'b0;
            if (q.cnt >= MIN_CNT) begin
                d.vld = 1'b1;
                d.len = q.cnt;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign len_vld_o = q.vld;
    assign len_o     = q.len;

endmodule

// File: rtl/abd_tx.sv
module abd_tx #(
    parameter int DIV_W = 13,
    parameter int OSR   = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tx_o,
    output logic             done_o
);

    localparam int PER_W    = DIV_W + $clog2(OSR) + 1;
    localparam int FRAME    = 10;              // start + 8 data + stop
    localparam int IDX_W    = $clog2(FRAME);
    localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(FRAME - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [PER_W-1:0] tmr;
        logic             tx;
        logic             done;
    } tx_t;

    tx_t q, d;
    logic [PER_W-1:0] per_last;

    always_comb begin
        per_last = PER_W'(div_i) * PER_W'(OSR) - PER_W'(1);
        d        = q;
        d.done   = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.idx  = '0;
                d.tmr  = '0;
                d.tx   = 1'b0;
            end
        end else if (q.tmr == per_last) begin
            d.tmr = '0;
            if (q.idx == STOP_IDX) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.tx   = 1'b1;
            end else begin
                d.idx = q.idx + 1'b1;
                // all data bits are zero, only the stop bit is high
                d.tx  = (q.idx + 1'b1 == STOP_IDX);
            end
        end else begin
            d.tmr = q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q    <= '0;
            q.tx <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_o   = q.tx;
    assign done_o = q.done;

endmodule

// File: rtl/autobaud_lock.sv
module autobaud_lock #(
    parameter  int CNT_W    = 20,
    parameter  int MIN_LOW  = 144,
    parameter  int OSR      = 16,
    parameter  int LOW_BITS = 9,
    localparam int SPAN     = OSR * LOW_BITS,
    localparam int DIV_W    = CNT_W + 2 - $clog2(SPAN)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rx_i,
    output logic             tx_o,
    output logic [DIV_W-1:0] divisor_o,
    output logic             locked_o
);

    import abd_pkg::*;

    localparam logic [CNT_W:0] SPAN_W = (CNT_W+1)'(SPAN);
    localparam logic [CNT_W:0] HALF_W = (CNT_W+1)'(SPAN / 2);

    typedef struct packed {
        abd_state_e       st;
        logic [DIV_W-1:0] div;
        logic             start;
        logic             locked;
    } top_t;

    top_t q, d;

    logic             rx_s;
    logic             len_vld;
    logic [CNT_W-1:0] len;
    logic             tx_done;
    logic [CNT_W:0]   sum;

    abd_sync #(.STAGES(2)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (rx_i),
        .sync_o  (rx_s)
    );

    abd_measure #(.CNT_W(CNT_W), .MIN_LOW(MIN_LOW)) meas_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rx_s_i    (rx_s),
        .en_i      (q.st == ST_HUNT),
        .len_vld_o (len_vld),
        .len_o     (len)
    );

    abd_tx #(.DIV_W(DIV_W), .OSR(OSR)) tx_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (q.start),
        .div_i   (q.div),
        .tx_o    (tx_o),
        .done_o  (tx_done)
    );

    always_comb begin
        sum     = {1'b0, len} + HALF_W;
        d       = q;
        d.start = 1'b0;
        unique case (q.st)
            ST_HUNT: begin
                if (len_vld) begin
                    d.div   = DIV_W'(sum / SPAN_W);
                    d.start = 1'b1;
                    d.st    = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_done) begin
                    d.locked = 1'b1;
                    d.st     = ST_DONE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q    <= '0;
            q.st <= ST_HUNT;
        end else begin
            q <= d;
        end
    end

    assign divisor_o = q.div;
    assign locked_o  = q.locked;

endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
    parameter int DIV_W = 13
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tx_o,
    input logic [DIV_W-1:0] divisor_o,
    input logic             locked_o
);

    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |=> locked_o);                                  // R7

    AST_DIV_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (divisor_o != '0) |=> $stable(divisor_o));               // R8

    AST_TX_IDLE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |-> tx_o);                                      // R9

    AST_TX_IDLE_UNSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (divisor_o == '0) |-> tx_o);                             // R9

    AST_DIV_NONZERO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |-> (divisor_o != '0));                         // R3

endmodule

bind autobaud_lock abd_checker #(.DIV_W(DIV_W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_o      (tx_o),
    .divisor_o (divisor_o),
    .locked_o  (locked_o)
);

// File: tb/autobaud_lock_tb_top.sv
module autobaud_lock_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 12;
    localparam int MIN_LOW    = 144;
    localparam int OSR        = 16;
    localparam int SPAN       = 144;
    localparam int MAX_CNT    = (1 << CNT_W) - 1;
    localparam int DIV_W      = CNT_W + 2 - $clog2(SPAN);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx = 1'b1;
    logic             tx;
    logic [DIV_W-1:0] divisor;
    logic             locked;

    int checks = 0;
    int errors = 0;

    autobaud_lock #(.CNT_W(CNT_W), .MIN_LOW(MIN_LOW), .OSR(OSR), .LOW_BITS(9)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .rx_i      (rx),
        .tx_o      (tx),
        .divisor_o (divisor),
        .locked_o  (locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_div(int len);
        return (len + SPAN/2) / SPAN;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx    = 1'b1;
        repeat (4) @(negedge clk);
        check(tx == 1'b1,   "R1", "tx in reset", tx, 1);
        check(locked == 0,  "R1", "locked in reset", locked, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(divisor == 0, "R1", "divisor after reset", divisor, 0);
    endtask

    task automatic send_low(int len);
        @(negedge clk);
        rx = 1'b0;
        repeat (len) @(negedge clk);
        rx = 1'b1;
    endtask

    task automatic expect_silence(string req, int n);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx == 1'b0) lows++;
        end
        check(lows == 0, req, "tx low samples while idle", lows, 0);
    endtask

    task automatic measure_frame(int d_exp, string tag);
        bit seen = 1'b0;
        int low  = 1;
        int k    = 0;
        for (int i = 0; i < 300 && !seen; i++) begin
            @(negedge clk);
            if (tx == 1'b0) seen = 1'b1;
        end
        check(seen, "R6", {tag, " start bit seen"}, seen, 1);
        if (!seen) return;
        forever begin
            @(negedge clk);
            if (tx == 1'b1 || low > 100000) break;
            low++;
        end
        check(low == SPAN * d_exp, "R6", {tag, " frame low clocks"}, low, SPAN * d_exp);
        while (!locked && k < 100000) begin
            @(negedge clk);
            k++;
        end
        check(k == OSR * d_exp + 1, "R7", {tag, " stop bit to lock"}, k, OSR * d_exp + 1);
    endtask

    task automatic run_trial(int len, bit extra, string tag);
        int d_exp = exp_div(len);
        do_reset();
        repeat (10) @(negedge clk);
        send_low(len);
        fork
            begin
                if (extra) begin
                    repeat (8) @(negedge clk);
                    send_low(300);
                end
            end
            measure_frame(d_exp, tag);
        join
        check(divisor == DIV_W'(d_exp), "R3", {tag, " divisor"}, int'(divisor), d_exp);
        repeat (5) @(negedge clk);
        send_low(160);
        expect_silence("R8", 40);
        check(divisor == DIV_W'(d_exp), "R8", {tag, " divisor after lock"}, int'(divisor), d_exp);
        check(locked == 1'b1, "R7", {tag, " lock held"}, locked, 1);
        check(tx == 1'b1, "R9", {tag, " tx idle after lock"}, tx, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));

        // R4 and R5: discarded runs, then a good one still locks
        do_reset();
        repeat (10) @(negedge clk);
        send_low(MIN_LOW - 1);
        expect_silence("R4", 40);
        check(divisor == 0, "R4", "divisor after short run", int'(divisor), 0);
        repeat (10) @(negedge clk);
        send_low(MAX_CNT + 1);
        expect_silence("R5", 40);
        check(divisor == 0, "R5", "divisor after long run", int'(divisor), 0);
        check(locked == 0, "R5", "locked after discards", locked, 0);
        repeat (10) @(negedge clk);
        send_low(200);
        measure_frame(exp_div(200), "after discards");
        check(divisor == DIV_W'(exp_div(200)), "R4", "divisor after restart", int'(divisor), exp_div(200));

        // R2: counts exact to one clock around a rounding step
        run_trial(MIN_LOW, 1'b0, "R2 minimum");
        run_trial(215, 1'b1, "R2 round down");
        run_trial(216, 1'b0, "R2 round up");
        run_trial(MAX_CNT, 1'b1, "R5 limit");

        for (int t = 0; t < 8; t++) begin
            run_trial(int'($urandom_range(2000, MIN_LOW)), t[0], "R3 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule